// File: doc/BRIEF.md
# Pipelined Fixed-Point PLL Loop Filter

This block is the proportional-plus-integral loop filter of a second-order phase lock loop. It runs at a decimated update rate, well below the phase-detector rate. Each accepted sample x(n) is one step of the filter

  B(z) = γ·(1 + β1·z⁻¹) / (1 + α1·z⁻¹)

The structure is a one-pole recursion followed by a one-zero sum. A pipeline register sits between the zero sum and the final gain multiply, so only one multiplier lies on any register-to-register path. The cost is one extra update period of delay in the loop response.

Arithmetic is signed two's complement with a fixed format on every bus.

- The 8-bit phase error is an integer. It is widened to a 32-bit word with 8 fraction bits.
- The pole coefficient is supplied already negated as −α1. It and the zero coefficient β1 are 16-bit fractions with 15 fraction bits.
- The gain γ has 7 fraction bits.
- Every product is brought back to 32 bits by dropping low bits. There is no rounding and no saturation.

The result is a 32-bit signed integer control word for a numerically controlled oscillator.

Samples enter on a valid/ready stream and results leave on another.

- An input sample is accepted when `in_valid` and `in_ready` are both high. Each accepted sample produces exactly one output word.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output word is held and no new sample is accepted. Back-pressure therefore stalls the whole filter, and the filter state is never skipped.
- The coefficient inputs are plain levels. They are sampled on each accepted sample.

Top module: `lf_loop_filter`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the state register, the pipeline register and the output word to zero, and clears `out_valid`.
- R2: The input sample is taken as a signed integer from -128 to +127 and enters the datapath as x·256, a 32-bit word with 8 fraction bits. With −α1 = 0, β1 = 0 and γ = 128 (1.0 with 7 fraction bits), the output word equals the sample accepted one step earlier.
- R3: On each accepted sample the state becomes c(n) = x(n)·256 + P(−α1, c(n−1)). Here P(k, v) = floor(k·v / 2^15) kept to 32 bits, and −α1 is a 16-bit signed value with 15 fraction bits.
- R4: Every product is reduced by an arithmetic right shift of 15 bits, which rounds toward minus infinity. The result keeps the low 32 bits, so it wraps instead of saturating; for example γ = 1 applied to −256 gives −1, and applied to +256 gives 0.
- R5: On each accepted sample the zero sum w(n) = c(n) + P(β1, c(n−1)), with 32-bit wrap-around, is captured in the pipeline register. β1 is a 16-bit signed value with 15 fraction bits.
- R6: After accepting sample n, the output word is floor(γ·w(n−1) / 2^15) kept to 32 bits, where γ is 16-bit signed with 7 fraction bits. The output therefore lags the zero sum by exactly one update.
- R7: In a cycle with no accepted sample, the state, the pipeline register and the output word do not change.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_ctrl` stays unchanged on the next cycle.
- R9: `out_valid` is high in the cycle after every accepted sample. It goes low after a cycle in which `out_ready` was high and no sample was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Phase-error sample valid |
| in_ready | output | 1 | Filter can accept a sample |
| in_err | input | 8 | Signed phase-error sample (integer) |
| coef_pole | input | 16 | −α1, signed, 15 fraction bits |
| coef_zero | input | 16 | β1, signed, 15 fraction bits |
| coef_gain | input | 16 | γ, signed, 8 integer and 7 fraction bits |
| out_valid | output | 1 | Control word valid |
| out_ready | input | 1 | Downstream accepts the control word |
| out_ctrl | output | 32 | Signed integer control word |

## Verification
The bench uses four kinds of input pattern.

- With a unity-gain pass-through setting, single samples isolate the input widening and the single-step delay of the output (R2, R6).
- Impulses with only the pole term set, and then only the zero term set, separate the recursion (R3) from the zero sum (R5). A wrongly wired coefficient shows up as a wrong decay value.
- Small positive and negative values under the smallest gain distinguish floor truncation from rounding toward zero (R4).
- Long random runs draw near-integrator pole values and random zeros, gains, gaps in `in_valid` and stalls on `out_ready`. They compare every output word against a bench model, which exposes state corruption during stalls and idle cycles (R7, R8, R9).

// File: rtl/lf_pkg.sv
package lf_pkg;
  // Default fixed-point geometry of the loop filter datapath.
  localparam int unsigned LF_DATA_W  = 32; // state / pipeline / output width
  localparam int unsigned LF_ERR_W   = 8;  // phase-error sample width
  localparam int unsigned LF_ERR_SH  = 8;  // fraction bits added to the sample
  localparam int unsigned LF_COEF_W  = 16; // coefficient width
  localparam int unsigned LF_COEF_FR = 15; // fraction bits of pole/zero coefs
  localparam int unsigned LF_GAIN_FR = 7;  // fraction bits of the gain
endpackage

// File: rtl/lf_frac_mul.sv
// Signed fractional multiply: full product, then an arithmetic bit slice
// that drops SHIFT low bits and keeps AW bits (floor, wrap, no saturation).
module lf_frac_mul #(
  parameter int unsigned AW    = 32,
  parameter int unsigned BW    = 16,
  parameter int unsigned SHIFT = 15
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [AW-1:0] y
);
  localparam int unsigned PW = AW + BW;
  localparam int unsigned HI = SHIFT + AW;

  logic signed [PW-1:0] prod;
  assign prod = PW'(a) * PW'(b);
  assign y    = prod[HI-1:SHIFT];

  // Bits discarded by the slice: redundant top bits and the low fraction.
  generate
    if (SHIFT > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^prod[SHIFT-1:0];
    end
    if (PW > HI) begin : g_high
      logic unused_high;
      assign unused_high = ^prod[PW-1:HI];
    end
  endgenerate
endmodule

// File: rtl/lf_flow_ctl.sv
// Stream control: one accepted sample advances every filter register once.
module lf_flow_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic step,
  output logic out_valid
);
  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (step)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/lf_state_stage.sv
// Recursive part and zero sum: c(n) = xs + P(-a1, c(n-1)); w(n) = c(n) + P(b1, c(n-1)).
module lf_state_stage #(
  parameter int unsigned DW  = 32,
  parameter int unsigned XW  = 8,
  parameter int unsigned XSH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned CFR = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [XW-1:0] x,
  input  logic signed [CW-1:0] k_pole,
  input  logic signed [CW-1:0] k_zero,
  output logic signed [DW-1:0] w_next
);
  localparam int unsigned EXT = DW - XW - XSH;

  logic signed [DW-1:0] c_q;
  logic signed [DW-1:0] x_wide;
  logic signed [DW-1:0] fb_term;
  logic signed [DW-1:0] zr_term;
  logic signed [DW-1:0] c_next;

  assign x_wide = {{EXT{x[XW-1]}}, x, {XSH{1'b0}}};

  lf_frac_mul #(.AW(DW), .BW(CW), .SHIFT(CFR)) u_pole_mul (
    .a(c_q), .b(k_pole), .y(fb_term)
  );

  lf_frac_mul #(.AW(DW), .BW(CW), .SHIFT(CFR)) u_zero_mul (
    .a(c_q), .b(k_zero), .y(zr_term)
  );

  assign c_next = x_wide + fb_term;
  assign w_next = c_next + zr_term;

  always_ff @(posedge clk) begin
    if (!rst_n)    c_q <= '0;
    else if (step) c_q <= c_next;
  end
endmodule

// File: rtl/lf_gain_stage.sv
// Pipeline register on the zero sum, then the gain product into the output word.
module lf_gain_stage #(
  parameter int unsigned DW  = 32,
  parameter int unsigned GW  = 16,
  parameter int unsigned GSH = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [DW-1:0] w_in,
  input  logic signed [GW-1:0] k_gain,
  output logic signed [DW-1:0] y_q
);
  logic signed [DW-1:0] pipe_q;
  logic signed [DW-1:0] y_next;

  lf_frac_mul #(.AW(DW), .BW(GW), .SHIFT(GSH)) u_gain_mul (
    .a(pipe_q), .b(k_gain), .y(y_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
      y_q    <= '0;
    end else if (step) begin
      pipe_q <= w_in;
      y_q    <= y_next;
    end
  end
endmodule

// File: rtl/lf_loop_filter.sv
module lf_loop_filter
  import lf_pkg::*;
#(
  parameter int unsigned DATA_W  = LF_DATA_W,
  parameter int unsigned ERR_W   = LF_ERR_W,
  parameter int unsigned ERR_SH  = LF_ERR_SH,
  parameter int unsigned COEF_W  = LF_COEF_W,
  parameter int unsigned COEF_FR = LF_COEF_FR,
  parameter int unsigned GAIN_FR = LF_GAIN_FR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ERR_W-1:0]  in_err,
  input  logic [COEF_W-1:0] coef_pole,
  input  logic [COEF_W-1:0] coef_zero,
  input  logic [COEF_W-1:0] coef_gain,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_ctrl
);
  // Gain product carries the sample fraction plus the gain fraction.
  localparam int unsigned GAIN_SH = ERR_SH + GAIN_FR;

  logic                     step;
  logic signed [DATA_W-1:0] w_sum;
  logic signed [DATA_W-1:0] y_word;

  lf_flow_ctl u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .step     (step),
    .out_valid(out_valid)
  );

  lf_state_stage #(
    .DW(DATA_W), .XW(ERR_W), .XSH(ERR_SH), .CW(COEF_W), .CFR(COEF_FR)
  ) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .x     ($signed(in_err)),
    .k_pole($signed(coef_pole)),
    .k_zero($signed(coef_zero)),
    .w_next(w_sum)
  );

  lf_gain_stage #(
    .DW(DATA_W), .GW(COEF_W), .GSH(GAIN_SH)
  ) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .w_in  (w_sum),
    .k_gain($signed(coef_gain)),
    .y_q   (y_word)
  );

  assign out_ctrl = y_word;
endmodule

// File: rtl/lf_loop_filter_chk.sv
module lf_loop_filter_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_ctrl
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && out_ctrl == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_ctrl));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ctrl)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind lf_loop_filter lf_loop_filter_chk #(.DW(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_ctrl (out_ctrl)
);

// File: tb/tb_lf_loop_filter.sv
module tb_lf_loop_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [7:0]  in_err = '0;
  logic [15:0] k_pole = '0;
  logic [15:0] k_zero = '0;
  logic [15:0] k_gain = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_ctrl;

  int checks = 0;
  int errors = 0;

  // bench model state: filter state, pipeline and expected output
  logic [31:0] m_c = '0;
  logic [31:0] m_p = '0;
  logic [31:0] m_y = '0;

  always #5 clk = ~clk;

  lf_loop_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_err(in_err), .coef_pole(k_pole), .coef_zero(k_zero),
    .coef_gain(k_gain), .out_valid(out_valid), .out_ready(out_ready),
    .out_ctrl(out_ctrl)
  );

  // floor(k*v / 2^15) kept to 32 bits
  function automatic logic [31:0] fmul(input logic [31:0] v, input logic [15:0] k);
    longint p;
    p = longint'($signed(v)) * longint'($signed(k));
    p = p >>> 15;
    return p[31:0];
  endfunction

  function automatic logic [31:0] widen(input logic [7:0] x);
    int t;
    t = int'($signed(x)) * 256;
    return t;
  endfunction

  task automatic model_step(input logic [7:0] x);
    logic [31:0] cn;
    logic [31:0] wn;
    cn  = widen(x) + fmul(m_c, k_pole);
    wn  = cn + fmul(m_c, k_zero);
    m_y = fmul(m_p, k_gain);
    m_p = wn;
    m_c = cn;
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_c = '0; m_p = '0; m_y = '0;
    #1;
    // R1: cleared outputs after reset
    chk_eq("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk_eq("R1 out_ctrl", out_ctrl, 32'd0);
    chk_eq("R1 in_ready", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
  endtask

  // one cycle: drive at negedge, check result at following negedge
  task automatic cycle(input bit v, input logic [7:0] x, input bit rdy);
    bit acc;
    bit pov;
    logic [31:0] py;
    in_valid = v; in_err = x; out_ready = rdy;
    #1;
    chk_eq("R8 in_ready", {31'b0, in_ready}, {31'b0, (!out_valid || rdy)});
    acc = v && in_ready;
    pov = out_valid;
    py  = out_ctrl;
    @(posedge clk);
    @(negedge clk);
    if (acc) begin
      model_step(x);
      chk_eq("R9 valid after accept", {31'b0, out_valid}, 32'd1);
      chk_eq("R6 output word (R3 R5)", out_ctrl, m_y);
    end else if (pov && !rdy) begin
      chk_eq("R8 stall valid", {31'b0, out_valid}, 32'd1);
      chk_eq("R8 stall data", out_ctrl, py);
    end else begin
      chk_eq("R9 drop valid", {31'b0, out_valid}, 32'd0);
      chk_eq("R7 idle hold", out_ctrl, py);
    end
    in_valid = 1'b0;
  endtask

  task automatic set_coefs(input logic [15:0] p, input logic [15:0] z, input logic [15:0] g);
    k_pole = p; k_zero = z; k_gain = g;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250117));

    // R2 / R6: unity pass-through, one update of delay
    set_coefs(16'd0, 16'd0, 16'd128);
    do_reset();
    cycle(1'b1, 8'd5, 1'b1);
    chk_eq("R6 first word zero", out_ctrl, 32'd0);
    cycle(1'b1, 8'h80, 1'b1);
    chk_eq("R2 pass +5", out_ctrl, 32'd5);
    cycle(1'b1, 8'd0, 1'b1);
    chk_eq("R2 pass -128", out_ctrl, 32'hFFFF_FF80);

    // R4: floor truncation with smallest gain
    set_coefs(16'd0, 16'd0, 16'd1);
    do_reset();
    cycle(1'b1, 8'hFF, 1'b1);
    cycle(1'b1, 8'd1, 1'b1);
    chk_eq("R4 floor of -256", out_ctrl, 32'hFFFF_FFFF);
    cycle(1'b1, 8'd0, 1'b1);
    chk_eq("R4 floor of +256", out_ctrl, 32'd0);

    // R3: pole only (-a1 = 0.5), impulse of 8 decays by half
    set_coefs(16'd16384, 16'd0, 16'd128);
    do_reset();
    cycle(1'b1, 8'd8, 1'b1);
    cycle(1'b1, 8'd0, 1'b1);
    chk_eq("R3 step1", out_ctrl, 32'd8);
    cycle(1'b1, 8'd0, 1'b1);
    chk_eq("R3 step2", out_ctrl, 32'd4);

    // R5: zero only (b1 = 0.5), impulse of 4 gives 4 then 2
    set_coefs(16'd0, 16'd16384, 16'd128);
    do_reset();
    cycle(1'b1, 8'd4, 1'b1);
    cycle(1'b1, 8'd0, 1'b1);
    chk_eq("R5 direct term", out_ctrl, 32'd4);
    cycle(1'b1, 8'd0, 1'b1);
    chk_eq("R5 delayed term", out_ctrl, 32'd2);

    // R7 / R8 directed: stall holds word, idle holds word
    cycle(1'b1, 8'd7, 1'b0);
    cycle(1'b1, 8'd9, 1'b0);
    cycle(1'b0, 8'd9, 1'b0);
    cycle(1'b0, 8'd0, 1'b1);
    cycle(1'b0, 8'd0, 1'b1);

    // Near-integrator with constant large input (R3 R5 R6)
    set_coefs(16'd32767, 16'hC000, 16'd300);
    do_reset();
    for (int i = 0; i < 120; i++) cycle(1'b1, 8'd127, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b1, 8'h80, 1'b1);

    // Random phases: coefficients, samples, gaps and stalls (R3 to R9)
    for (int ph = 0; ph < 4; ph++) begin
      if (ph < 2)
        set_coefs(16'(32'd30000 + ($urandom % 2768)), 16'(-(int'($urandom % 32768))),
                  16'($urandom));
      else
        set_coefs(16'($urandom), 16'($urandom), 16'($urandom));
      do_reset();
      for (int i = 0; i < 400; i++)
        cycle(($urandom % 4) != 0, 8'($urandom), ($urandom % 3) != 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule